// File: doc/BRIEF.md
# JTAG Shift Engine

A host-side sequencer that drives the TCK, TMS and TDI lines of a JTAG port and samples TDO. It accepts one command at a time over a valid/ready handshake. A command can be a TAP reset, a run of idle clocks, an instruction-register shift or a data-register shift. TCK is derived from the system clock by a programmable divider, and it is parked low whenever no command is running.

For a shift, the engine walks the target TAP from Run-Test/Idle into the matching Shift state. It sends the requested number of bits, LSB first. The last bit goes out on the same TCK cycle in which TMS is raised, so the target leaves Shift through Exit1, passes Update and returns to Run-Test/Idle. The shifted value is therefore latched, not left pending. TDI is driven and TDO is sampled on that final bit as on every other bit. When capture is requested, the TDO bits are returned with the completion pulse.

Top module: `tap_shift_master`

## Requirements
- R1: After reset, cmd_ready_o is 1, done_o is 0, and tck_o, tms_o and tdi_o are all 0.
- R2: cmd_ready_o is low from the cycle after a command is accepted until the cycle in which done_o pulses. done_o is a single-cycle pulse and is high only while cmd_ready_o is high.
- R3: Every TCK period lasts 2*HALF_PERIOD clock cycles, low half first. TMS and TDI change only when TCK falls or while TCK is parked. TCK stays low while idle. A command of S TCK cycles raises done_o 2*HALF_PERIOD*S clock cycles after the accepting edge.
- R4: A DR shift (op code 3) of n bits sends TMS 1,0,0 from Run-Test/Idle, then n shift cycles, then TMS 1,0. That is n+5 TCK cycles in total, and the target ends in Run-Test/Idle after an Update-DR.
- R5: An IR shift (op code 2) of n bits sends TMS 1,1,0,0, then n shift cycles, then TMS 1,0. That is n+6 TCK cycles in total, and the target ends in Run-Test/Idle after an Update-IR.
- R6: TDI carries cmd_data_i bit i in shift cycle i, LSB first. The final bit is sent with TMS=1, so the register the target updates equals cmd_data_i[n-1:0].
- R7: TDO is sampled at each TCK rise, including the last shift bit. With capture set, done_data_o bit i holds the TDO value from shift cycle i, and bits n and above are 0.
- R8: With cmd_capture_i at 0, and for reset and idle commands, done_data_o is all zeros.
- R9: The TAP reset command (op code 0) issues RESET_CYCLES TCK cycles with TMS=1 and then one with TMS=0. From any TAP state this passes Test-Logic-Reset and ends in Run-Test/Idle.
- R10: The idle command (op code 1) issues cmd_len_i TCK cycles with TMS=0, for any count up to 255. A count of 0 gives a done_o pulse on the edge that accepts the command, with no TCK.
- R11: A shift count of 0 is treated as 1 bit, and a count above DATA_W is treated as DATA_W bits.
- R12: cmd_valid_i asserted while the engine is busy has no effect. The fields of the running command are latched when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_op_i | input | 2 | 0 TAP reset, 1 idle, 2 IR shift, 3 DR shift |
| cmd_len_i | input | LEN_W | Bit count for shifts, TCK count for idle |
| cmd_data_i | input | DATA_W | Bits to shift out, LSB first |
| cmd_capture_i | input | 1 | Return captured TDO bits |
| done_o | output | 1 | One-cycle completion pulse |
| done_data_o | output | DATA_W | Captured TDO bits, valid with done_o |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |

## Verification
The hardest case to reach from the ports is the last shift bit, which coincides with the Shift-to-Exit1 transition. A misplaced TMS edge there either drops that bit or leaves Update unvisited, and the engine's own outputs look plausible in both cases. The bench therefore runs a full sixteen-state TAP model on the generated TCK. The model loads known capture patterns, shifts TDI into a wide register and records what Update latches. It also starts in a paused IR state, so the reset command has to recover from somewhere other than Idle. Shifts whose top bit is 1, the one-bit and clamped lengths, and a command offered while busy all show up as a latched value, a TCK count or a final TAP state that is wrong.

// File: rtl/tap_shift_pkg.sv
package tap_shift_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IDLE  = 2'd1,
    OP_IR    = 2'd2,
    OP_DR    = 2'd3
  } tap_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SHIFT,
    PH_POST,
    PH_RESET,
    PH_RUN
  } phase_e;
endpackage

// File: rtl/tap_tck_gen.sv
module tap_tck_gen #(
  parameter int HALF_PERIOD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tck_q;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == CNT_LAST);
  assign rise_o = wrap && !tck_q;
  assign fall_o = wrap && tck_q;
  assign tck_o  = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tap_tdo_capture.sv
module tap_tdo_capture #(
  parameter int DATA_W = 38,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              tdo_i,
  output logic [DATA_W-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bits_o <= '0;
    else if (clear_i)  bits_o <= '0;
    else if (sample_i) bits_o[idx_i] <= tdo_i;
  end
endmodule

// File: rtl/tap_step_seq.sv
module tap_step_seq
  import tap_shift_pkg::*;
#(
  parameter int DATA_W       = 38,
  parameter int LEN_W        = 8,
  parameter int IDX_W        = 6,
  parameter int RESET_CYCLES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_capture_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              run_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              cap_clear_o,
  output logic              cap_sample_o,
  output logic [IDX_W-1:0]  cap_idx_o,
  input  logic [DATA_W-1:0] cap_bits_i,
  output logic              done_o,
  output logic [DATA_W-1:0] done_data_o
);
  localparam logic [LEN_W-1:0] ONE      = LEN_W'(1);
  localparam logic [LEN_W-1:0] MAX_BITS = LEN_W'(DATA_W);
  localparam logic [LEN_W-1:0] RST_CNT  = LEN_W'(RESET_CYCLES);

  phase_e             phase_q, nxt_phase, start_phase;
  logic [LEN_W-1:0]   step_q, nxt_step;
  logic [LEN_W-1:0]   len_q, start_len;
  logic [DATA_W-1:0]  data_q;
  logic               is_ir_q, cap_en_q, run_q, tms_q, tdi_q, done_q;
  logic [DATA_W-1:0]  done_data_q;
  logic               accept, is_shift_op;
  tap_op_e            op;

  // TMS level for a given step of a given phase
  function automatic logic tms_for(phase_e ph, logic [LEN_W-1:0] st,
                                   logic [LEN_W-1:0] ln, logic ir);
    case (ph)
      PH_PRE:   return (st == '0) || (ir && st == ONE);
      PH_SHIFT: return st == (ln - ONE);
      PH_POST:  return st == '0;
      PH_RESET: return st < RST_CNT;
      default:  return 1'b0;
    endcase
  endfunction

  assign op          = tap_op_e'(cmd_op_i);
  assign cmd_ready_o = (phase_q == PH_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign is_shift_op = (op == OP_IR) || (op == OP_DR);

  always_comb begin
    start_len = cmd_len_i;
    if (is_shift_op) begin
      if (cmd_len_i == '0)           start_len = ONE;
      else if (cmd_len_i > MAX_BITS) start_len = MAX_BITS;
    end
    case (op)
      OP_RESET: start_phase = PH_RESET;
      OP_IDLE:  start_phase = (cmd_len_i == '0) ? PH_IDLE : PH_RUN;
      default:  start_phase = PH_PRE;
    endcase
  end

  always_comb begin
    nxt_phase = phase_q;
    nxt_step  = step_q + ONE;
    case (phase_q)
      PH_PRE:
        if (step_q == (is_ir_q ? LEN_W'(3) : LEN_W'(2))) begin
          nxt_phase = PH_SHIFT;
          nxt_step  = '0;
        end
      PH_SHIFT:
        if (step_q == len_q - ONE) begin
          nxt_phase = PH_POST;
          nxt_step  = '0;
        end
      PH_POST:
        if (step_q == ONE) nxt_phase = PH_IDLE;
      PH_RESET:
        if (step_q == RST_CNT) nxt_phase = PH_IDLE;
      PH_RUN:
        if (step_q == len_q - ONE) nxt_phase = PH_IDLE;
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      step_q      <= '0;
      len_q       <= '0;
      data_q      <= '0;
      is_ir_q     <= 1'b0;
      cap_en_q    <= 1'b0;
      run_q       <= 1'b0;
      tms_q       <= 1'b0;
      tdi_q       <= 1'b0;
      done_q      <= 1'b0;
      done_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        data_q   <= cmd_data_i;
        len_q    <= start_len;
        is_ir_q  <= (op == OP_IR);
        cap_en_q <= cmd_capture_i && is_shift_op;
        step_q   <= '0;
        phase_q  <= start_phase;
        run_q    <= (start_phase != PH_IDLE);
        tms_q    <= tms_for(start_phase, '0, start_len, op == OP_IR);
        tdi_q    <= 1'b0;
        if (start_phase == PH_IDLE) begin
          done_q      <= 1'b1;
          done_data_q <= '0;
        end
      end else if (fall_i) begin
        phase_q <= nxt_phase;
        step_q  <= nxt_step;
        tms_q   <= tms_for(nxt_phase, nxt_step, len_q, is_ir_q);
        tdi_q   <= (nxt_phase == PH_SHIFT) ? data_q[nxt_step[IDX_W-1:0]] : 1'b0;
        if (nxt_phase == PH_IDLE) begin
          run_q       <= 1'b0;
          tms_q       <= 1'b0;
          done_q      <= 1'b1;
          done_data_q <= cap_en_q ? cap_bits_i : '0;
        end
      end
    end
  end

  assign run_o        = run_q;
  assign tms_o        = tms_q;
  assign tdi_o        = tdi_q;
  assign cap_clear_o  = accept;
  assign cap_sample_o = rise_i && (phase_q == PH_SHIFT) && cap_en_q;
  assign cap_idx_o    = step_q[IDX_W-1:0];
  assign done_o       = done_q;
  assign done_data_o  = done_data_q;
endmodule

// File: rtl/tap_shift_master.sv
module tap_shift_master #(
  parameter int DATA_W       = 38,
  parameter int LEN_W        = 8,
  parameter int HALF_PERIOD  = 2,
  parameter int RESET_CYCLES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_capture_i,
  output logic              done_o,
  output logic [DATA_W-1:0] done_data_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic              run, rise, fall;
  logic              cap_clear, cap_sample;
  logic [IDX_W-1:0]  cap_idx;
  logic [DATA_W-1:0] cap_bits;

  tap_tck_gen #(.HALF_PERIOD(HALF_PERIOD)) i_tck_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tck_o  (tck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  tap_step_seq #(
    .DATA_W       (DATA_W),
    .LEN_W        (LEN_W),
    .IDX_W        (IDX_W),
    .RESET_CYCLES (RESET_CYCLES)
  ) i_step_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_ready_o   (cmd_ready_o),
    .cmd_op_i      (cmd_op_i),
    .cmd_len_i     (cmd_len_i),
    .cmd_data_i    (cmd_data_i),
    .cmd_capture_i (cmd_capture_i),
    .rise_i        (rise),
    .fall_i        (fall),
    .run_o         (run),
    .tms_o         (tms_o),
    .tdi_o         (tdi_o),
    .cap_clear_o   (cap_clear),
    .cap_sample_o  (cap_sample),
    .cap_idx_o     (cap_idx),
    .cap_bits_i    (cap_bits),
    .done_o        (done_o),
    .done_data_o   (done_data_o)
  );

  tap_tdo_capture #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_tdo_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (cap_clear),
    .sample_i (cap_sample),
    .idx_i    (cap_idx),
    .tdo_i    (tdo_i),
    .bits_o   (cap_bits)
  );
endmodule

// File: rtl/tap_shift_master_chk.sv
module tap_shift_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic done_o,
  input logic tck_o,
  input logic tms_o,
  input logic tdi_o
);
  // R2
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> !cmd_ready_o || done_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  // R3
  tck_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o && $past(tck_o) |-> $stable(tms_o) && $stable(tdi_o));

  // R3
  tck_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o && $past(cmd_ready_o) |-> !tck_o);
endmodule

bind tap_shift_master tap_shift_master_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .done_o      (done_o),
  .tck_o       (tck_o),
  .tms_o       (tms_o),
  .tdi_o       (tdi_o)
);

// File: tb/test_tap_shift_master.sv
`timescale 1ns/1ps
module test_tap_shift_master;
  localparam int DATA_W = 38;
  localparam int LEN_W  = 8;
  localparam int HALF   = 2;
  localparam logic [63:0] DR_CAP = 64'hC3A5_96F0_5A3C_E1D2;
  localparam logic [63:0] IR_CAP = 64'h0000_0000_0000_0005;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  len;
    logic [37:0] data;
    logic        cap;
    logic [15:0] tck;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'd0,   38'h0,           1'b0, 16'd6},
    '{2'd2, 8'd4,   38'hE,           1'b1, 16'd10},
    '{2'd3, 8'd38,  38'h2A_5A5A_C3C3, 1'b1, 16'd43},
    '{2'd3, 8'd8,   38'h81,          1'b0, 16'd13},
    '{2'd2, 8'd4,   38'h1,           1'b1, 16'd10},
    '{2'd1, 8'd64,  38'h0,           1'b0, 16'd64},
    '{2'd3, 8'd1,   38'h1,           1'b1, 16'd6},
    '{2'd1, 8'd0,   38'h0,           1'b0, 16'd0},
    '{2'd3, 8'd32,  38'hDEAD_BEEF,   1'b1, 16'd37},
    '{2'd1, 8'd200, 38'h0,           1'b0, 16'd200}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_capture = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [DATA_W-1:0] cmd_data = '0, done_data;
  logic done, tck, tms, tdi, tdo = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tap_shift_master #(.DATA_W(DATA_W), .LEN_W(LEN_W), .HALF_PERIOD(HALF)) i_tap_shift_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_len_i(cmd_len), .cmd_data_i(cmd_data),
    .cmd_capture_i(cmd_capture), .done_o(done), .done_data_o(done_data),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
  );

  // Target TAP model
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tst_e;
  tst_e st = PIR;
  logic [63:0] sr = '0, dr_lat = '0, ir_lat = '0;
  int cnt = 0, rises = 0, dr_upd = 0, ir_upd = 0;
  bit saw_tlr = 0;

  always @(posedge tck) begin
    rises++;
    case (st)
      TLR:  begin saw_tlr = 1; st = tms ? TLR : RTI; end
      RTI:  st = tms ? SDR : RTI;
      SDR:  st = tms ? SIR : CDR;
      CDR:  begin sr = DR_CAP; cnt = 0; st = tms ? E1DR : SHDR; end
      SHDR: begin sr = {tdi, sr[63:1]}; cnt++; st = tms ? E1DR : SHDR; end
      E1DR: st = tms ? UDR : PDR;
      PDR:  st = tms ? E2DR : PDR;
      E2DR: st = tms ? UDR : SHDR;
      UDR:  begin dr_lat = sr >> (64 - cnt); dr_upd++; st = tms ? SDR : RTI; end
      SIR:  st = tms ? TLR : CIR;
      CIR:  begin sr = IR_CAP; cnt = 0; st = tms ? E1IR : SHIR; end
      SHIR: begin sr = {tdi, sr[63:1]}; cnt++; st = tms ? E1IR : SHIR; end
      E1IR: st = tms ? UIR : PIR;
      PIR:  st = tms ? E2IR : PIR;
      E2IR: st = tms ? UIR : SHIR;
      default: begin ir_lat = sr >> (64 - cnt); ir_upd++; st = tms ? SDR : RTI; end
    endcase
  end

  always @(negedge tck) tdo <= sr[0];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] lowmask(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic int eff_len(input logic [1:0] op, input logic [7:0] len);
    if (op < 2) return int'(len);
    if (len == 0) return 1;
    if (len > DATA_W) return DATA_W;
    return int'(len);
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] len,
                         input logic [37:0] data, input logic cap,
                         input int exp_tck, input bit poke);
    int cycles, r0, d0, i0, n;
    string req;
    logic [63:0] exp_cap;
    req = (op == 2'd3) ? "R4" : (op == 2'd2) ? "R5" : (op == 2'd0) ? "R9" : "R10";
    n = eff_len(op, len);
    r0 = rises; d0 = dr_upd; i0 = ir_upd; saw_tlr = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_len = len; cmd_data = data; cmd_capture = cap;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    cycles = 0;
    @(negedge clk);
    if (exp_tck > 0) check(!cmd_ready, "R2 busy", 64'(cmd_ready), 64'd0);
    while (!done && cycles < 20000) begin
      if (poke && cycles == 3) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_len = 8'd9; cmd_data = '1; cmd_capture = 1'b0;
      end
      if (poke && cycles == 7) cmd_valid = 1'b0;
      @(negedge clk);
      cycles++;
    end
    check(cmd_ready, "R2 ready at done", 64'(cmd_ready), 64'd1);
    check(cycles == exp_tck * 2 * HALF, "R3 cycles", 64'(cycles), 64'(exp_tck * 2 * HALF));
    check(rises - r0 == exp_tck, {req, " tck count"}, 64'(rises - r0), 64'(exp_tck));
    check(st == RTI, {req, " end state"}, 64'(st), 64'(RTI));
    if (op == 2'd3) begin
      check(dr_upd - d0 == 1, "R4 update-dr", 64'(dr_upd - d0), 64'd1);
      check(dr_lat == (64'(data) & lowmask(n)), "R6 dr latched", dr_lat, 64'(data) & lowmask(n));
    end
    if (op == 2'd2) begin
      check(ir_upd - i0 == 1, "R5 update-ir", 64'(ir_upd - i0), 64'd1);
      check(ir_lat == (64'(data) & lowmask(n)), "R6 ir latched", ir_lat, 64'(data) & lowmask(n));
    end
    if (op == 2'd0) check(saw_tlr, "R9 passed reset", 64'(saw_tlr), 64'd1);
    exp_cap = (op >= 2 && cap) ? (((op == 2'd3) ? DR_CAP : IR_CAP) & lowmask(n)) : 64'd0;
    check(64'(done_data) == exp_cap, cap ? "R7 capture" : "R8 no capture",
          64'(done_data), exp_cap);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r0, d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cmd_ready == 1'b1 && done == 1'b0, "R1 ready/done", {62'd0, cmd_ready, done}, 64'd2);
    check({tck, tms, tdi} == 3'b000, "R1 jtag lines", 64'({tck, tms, tdi}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !tck && !tms && !tdi, "R1 after release",
          64'({cmd_ready, tck, tms, tdi}), 64'd8);

    for (int k = 0; k < NVEC; k++)
      run_cmd(VECS[k].op, VECS[k].len, VECS[k].data, VECS[k].cap, int'(VECS[k].tck), 1'b0);

    // R11 zero length -> 1 bit
    run_cmd(2'd3, 8'd0, 38'h3, 1'b1, 6, 1'b0);
    check(dr_lat == 64'd1, "R11 zero len", dr_lat, 64'd1);
    // R11 over length -> DATA_W bits
    run_cmd(2'd3, 8'd50, 38'h3F_0123_4567, 1'b1, 43, 1'b0);
    check(dr_lat == 64'h3F_0123_4567, "R11 over len", dr_lat, 64'h3F_0123_4567);
    run_cmd(2'd2, 8'd200, 38'h20_0000_0001, 1'b0, 44, 1'b0);
    check(ir_lat == 64'h20_0000_0001, "R11 ir over len", ir_lat, 64'h20_0000_0001);

    // R12 valid while busy ignored, fields latched
    run_cmd(2'd3, 8'd12, 38'hA5C, 1'b1, 17, 1'b1);
    check(dr_lat == 64'hA5C, "R12 latched fields", dr_lat, 64'hA5C);
    r0 = rises; d0 = dr_upd;
    repeat (20) @(negedge clk);
    check(rises == r0 && dr_upd == d0, "R12 no extra command", 64'(rises - r0), 64'd0);
    check(cmd_ready && !done, "R12 idle after", 64'({cmd_ready, done}), 64'd2);

    // R9 reset recovers from a paused DR state
    st = PDR;
    run_cmd(2'd0, 8'd0, 38'h0, 1'b0, 6, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule